// File: doc/BRIEF.md
# Five-Port Micro-op Dispatch Selector

This block holds a small pool of waiting micro-ops and decides, every cycle, which of them leave for five execution ports. Each pool entry records a class: complex integer, simple integer, floating point, load, store address or store data. Operand readiness comes in as one bit per entry, and a busy bit per port lets an occupied execution unit refuse work. Each cycle the block raises up to one grant per port, together with the index of the chosen entry, and frees every granted entry at the next clock edge.

The ports are not alike. Port 0 is shared by the full-function integer unit (shifts, multiplies, divides, address arithmetic) and the floating-point unit, so at most one of those can go per cycle. Port 1 takes only simple integer work such as add, subtract and branch target arithmetic. Ports 2, 3 and 4 are dedicated to loads, store addresses and store data. Selection on each port is oldest-first, using an age order that the block records as entries are written. A simple-integer micro-op goes to port 1 first, and uses port 0 only when port 1 is already taken or busy and it is older than every ready complex or floating-point micro-op.

Top module: `uop_dispatch_sel`

## Requirements
- R1: A grant is raised only for an entry that is occupied and whose ready bit is 1; an occupied entry whose ready bit is 0 is never granted.
- R2: Port 0 grants at most one micro-op per cycle, and only of class complex integer (code 0), floating point (code 2) or simple integer (code 1).
- R3: Port 1 grants only micro-ops of class simple integer (code 1).
- R4: Port 2 grants only loads (code 3), port 3 only store addresses (code 4) and port 4 only store data (code 5).
- R5: Among the ready entries eligible for a port, the one written earliest wins; the age order is set by the order of accepted writes, not by the entry index.
- R6: A ready simple-integer micro-op is granted on port 1 before port 0 is considered for it; it goes to port 0 only when port 1 is granted to an older simple micro-op or is busy, and no older complex or floating-point micro-op is ready.
- R7: No entry is granted on two ports in the same cycle.
- R8: A granted entry is no longer occupied after the clock edge that ends its grant cycle; a write to an entry that is occupied at that edge is ignored and leaves the entry's class unchanged.
- R9: When the busy bit of a port (bit p for port p) is 1, that port raises no grant in that cycle; for port 1 this lets simple micro-ops fall back to port 0 under R6.
- R10: After reset no entry is occupied and no port raises a grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_vld_i | input | 1 | Write a new micro-op into the pool this cycle |
| alloc_idx_i | input | IW | Entry to write (IW = clog2(ENTRIES)) |
| alloc_cls_i | input | 3 | Class code of the written micro-op (0 complex, 1 simple, 2 float, 3 load, 4 store address, 5 store data) |
| rdy_i | input | ENTRIES | Operand-ready bit per entry |
| busy_i | input | 5 | Per-port busy bit, bit p for port p |
| gnt_vld_o | output | 5 | Grant valid per port |
| gnt_idx_o | output | 5 x IW | Granted entry index per port |
| ent_vld_o | output | ENTRIES | Occupancy bit per entry |

## Verification
On every cycle the assertions check that each grant lands on an occupied, ready entry of a class the port may take, that two ports never carry the same entry, that a busy port stays silent, that a simple micro-op on port 0 only appears when port 1 is unavailable, that the age order stays antisymmetric across occupied pairs, and that granted entries vanish one edge later. Which entry actually wins cannot be seen from those local rules: oldest-first selection with entry indices out of age order, the fallback of a simple micro-op that is older than a waiting complex one, the ignored write to an occupied entry and the mid-run reset are shown only by the bench's scenarios, which compare every port's grant and the occupancy against hand-derived values.

// File: rtl/dsel_pkg.sv
package dsel_pkg;

    localparam int NPORT = 5;

    localparam int P_MAIN  = 0;
    localparam int P_SIMP  = 1;
    localparam int P_LOAD  = 2;
    localparam int P_STA   = 3;
    localparam int P_STD   = 4;

    typedef enum logic [2:0] {
        UC_CPLX = 3'd0,
        UC_SIMP = 3'd1,
        UC_FP   = 3'd2,
        UC_LOAD = 3'd3,
        UC_STA  = 3'd4,
        UC_STD  = 3'd5
    } uop_cls_e;

    // Class served by a dedicated memory port
    function automatic uop_cls_e mem_port_cls(input int port);
        case (port)
            P_LOAD:  return UC_LOAD;
            P_STA:   return UC_STA;
            default: return UC_STD;
        endcase
    endfunction

    // Classes that may only issue on the shared port 0
    function automatic logic needs_main_port(input uop_cls_e c);
        return (c == UC_CPLX) || (c == UC_FP);
    endfunction

endpackage

// File: rtl/rs_entry_table.sv
module rs_entry_table
    import dsel_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IW = $clog2(ENTRIES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  alloc_vld_i,
    input  logic [IW-1:0]         alloc_idx_i,
    input  uop_cls_e              alloc_cls_i,
    input  logic [ENTRIES-1:0]    free_i,
    output logic                  alloc_fire_o,
    output logic [ENTRIES-1:0]    vld_o,
    output uop_cls_e              cls_o [ENTRIES]
);

    logic [ENTRIES-1:0] vld_q;
    uop_cls_e           cls_q [ENTRIES];

    // A write lands only in an entry that is empty at this edge
    assign alloc_fire_o = alloc_vld_i && !vld_q[alloc_idx_i];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            for (int i = 0; i < ENTRIES; i++) cls_q[i] <= UC_CPLX;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (alloc_fire_o && (alloc_idx_i == IW'(i))) begin
                    vld_q[i] <= 1'b1;
                    cls_q[i] <= alloc_cls_i;
                end else if (free_i[i]) begin
                    vld_q[i] <= 1'b0;
                end
            end
        end
    end

    assign vld_o = vld_q;
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) cls_o[i] = cls_q[i];
    end

    // Freed entries must have been occupied
    AST_FREE_OCCUPIED: assert property (@(posedge clk) disable iff (rst)
        ((free_i & ~vld_q) == '0)) else $error("free of empty entry"); // R1

endmodule

// File: rtl/rs_age_tracker.sv
module rs_age_tracker #(
    parameter int ENTRIES = 8,
    localparam int IW = $clog2(ENTRIES)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              alloc_fire_i,
    input  logic [IW-1:0]                     alloc_idx_i,
    input  logic [ENTRIES-1:0]                vld_i,
    output logic [ENTRIES-1:0][ENTRIES-1:0]   older_o
);

    // older_q[a][b] = 1 when entry a was written before entry b
    logic [ENTRIES-1:0][ENTRIES-1:0] older_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            older_q <= '0;
        end else if (alloc_fire_i) begin
            for (int j = 0; j < ENTRIES; j++) begin
                if (IW'(j) != alloc_idx_i) begin
                    older_q[alloc_idx_i][j] <= 1'b0;
                    older_q[j][alloc_idx_i] <= 1'b1;
                end
            end
        end
    end

    assign older_o = older_q;

    generate
        for (genvar a = 0; a < ENTRIES; a++) begin : g_row
            for (genvar b = a + 1; b < ENTRIES; b++) begin : g_col
                AST_AGE_ANTISYM: assert property (@(posedge clk) disable iff (rst)
                    (vld_i[a] && vld_i[b]) |-> (older_q[a][b] != older_q[b][a]))
                    else $error("age order broken"); // R5
            end
        end
    endgenerate

endmodule

// File: rtl/rs_oldest_pick.sv
module rs_oldest_pick #(
    parameter int ENTRIES = 8,
    localparam int IW = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]                cand_i,
    input  logic [ENTRIES-1:0][ENTRIES-1:0]   older_i,
    output logic [ENTRIES-1:0]                win_o,
    output logic                              any_o,
    output logic [IW-1:0]                     idx_o
);

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            win_o[i] = cand_i[i];
            for (int j = 0; j < ENTRIES; j++) begin
                if (j != i && cand_i[j] && !older_i[i][j]) win_o[i] = 1'b0;
            end
        end
    end

    assign any_o = |cand_i;

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (win_o[i]) idx_o = idx_o | IW'(i);
        end
    end

endmodule

// File: rtl/uop_dispatch_sel.sv
module uop_dispatch_sel
    import dsel_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IW = $clog2(ENTRIES)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         alloc_vld_i,
    input  logic [IW-1:0]                alloc_idx_i,
    input  logic [2:0]                   alloc_cls_i,
    input  logic [ENTRIES-1:0]           rdy_i,
    input  logic [NPORT-1:0]             busy_i,
    output logic [NPORT-1:0]             gnt_vld_o,
    output logic [NPORT-1:0][IW-1:0]     gnt_idx_o,
    output logic [ENTRIES-1:0]           ent_vld_o
);

    logic                             alloc_fire;
    logic [ENTRIES-1:0]               ent_vld;
    uop_cls_e                         ent_cls [ENTRIES];
    logic [ENTRIES-1:0][ENTRIES-1:0]  older;
    logic [ENTRIES-1:0]               free_mask;

    logic [ENTRIES-1:0]               live;
    logic [ENTRIES-1:0]               simp_rdy;
    logic [ENTRIES-1:0]               main_rdy;
    logic [NPORT-1:0][ENTRIES-1:0]    cand;
    logic [NPORT-1:0][ENTRIES-1:0]    win;
    logic [NPORT-1:0]                 any;

    rs_entry_table #(.ENTRIES(ENTRIES)) u_table (
        .clk          (clk),
        .rst          (rst),
        .alloc_vld_i  (alloc_vld_i),
        .alloc_idx_i  (alloc_idx_i),
        .alloc_cls_i  (uop_cls_e'(alloc_cls_i)),
        .free_i       (free_mask),
        .alloc_fire_o (alloc_fire),
        .vld_o        (ent_vld),
        .cls_o        (ent_cls)
    );

    rs_age_tracker #(.ENTRIES(ENTRIES)) u_age (
        .clk          (clk),
        .rst          (rst),
        .alloc_fire_i (alloc_fire),
        .alloc_idx_i  (alloc_idx_i),
        .vld_i        (ent_vld),
        .older_o      (older)
    );

    // Ready, occupied entries sorted by class
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            live[i]     = ent_vld[i] && rdy_i[i];
            simp_rdy[i] = live[i] && (ent_cls[i] == UC_SIMP);
            main_rdy[i] = live[i] && needs_main_port(ent_cls[i]);
        end
    end

    // Port 1 is decided first; its winner is removed from port 0's pool
    assign cand[P_SIMP] = busy_i[P_SIMP] ? '0 : simp_rdy;
    assign cand[P_MAIN] = busy_i[P_MAIN] ? '0 :
                          (main_rdy | (simp_rdy & ~win[P_SIMP]));

    generate
        for (genvar p = P_LOAD; p < NPORT; p++) begin : g_mem
            always_comb begin
                for (int i = 0; i < ENTRIES; i++) begin
                    cand[p][i] = !busy_i[p] && live[i] && (ent_cls[i] == mem_port_cls(p));
                end
            end
        end

        for (genvar p = 0; p < NPORT; p++) begin : g_pick
            rs_oldest_pick #(.ENTRIES(ENTRIES)) u_pick (
                .cand_i  (cand[p]),
                .older_i (older),
                .win_o   (win[p]),
                .any_o   (any[p]),
                .idx_o   (gnt_idx_o[p])
            );
        end
    endgenerate

    always_comb begin
        free_mask = '0;
        for (int p = 0; p < NPORT; p++) free_mask = free_mask | win[p];
    end

    assign gnt_vld_o = any;
    assign ent_vld_o = ent_vld;

    // ------------------------------------------------------------------
    // Assertions
    // ------------------------------------------------------------------
    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_ast
            AST_GRANT_READY: assert property (@(posedge clk) disable iff (rst)
                gnt_vld_o[p] |-> (ent_vld_o[gnt_idx_o[p]] && rdy_i[gnt_idx_o[p]]))
                else $error("grant on unready entry"); // R1
            AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (rst)
                busy_i[p] |-> !gnt_vld_o[p])
                else $error("grant on busy port"); // R9
            AST_FREED_NEXT: assert property (@(posedge clk) disable iff (rst)
                gnt_vld_o[p] |=> !ent_vld_o[$past(gnt_idx_o[p])])
                else $error("granted entry not freed"); // R8
            for (genvar q = p + 1; q < NPORT; q++) begin : g_pair
                AST_NO_DOUBLE_GRANT: assert property (@(posedge clk) disable iff (rst)
                    (gnt_vld_o[p] && gnt_vld_o[q]) |-> (gnt_idx_o[p] != gnt_idx_o[q]))
                    else $error("entry on two ports"); // R7
            end
            if (p >= P_LOAD) begin : g_memcls
                AST_MEM_PORT_CLASS: assert property (@(posedge clk) disable iff (rst)
                    gnt_vld_o[p] |-> (ent_cls[gnt_idx_o[p]] == mem_port_cls(p)))
                    else $error("wrong class on memory port"); // R4
            end
        end
    endgenerate

    AST_MAIN_PORT_CLASS: assert property (@(posedge clk) disable iff (rst)
        gnt_vld_o[P_MAIN] |-> (ent_cls[gnt_idx_o[P_MAIN]] inside {UC_CPLX, UC_SIMP, UC_FP}))
        else $error("wrong class on port 0"); // R2
    AST_SIMPLE_PORT_CLASS: assert property (@(posedge clk) disable iff (rst)
        gnt_vld_o[P_SIMP] |-> (ent_cls[gnt_idx_o[P_SIMP]] == UC_SIMP))
        else $error("wrong class on port 1"); // R3
    AST_SIMPLE_FALLBACK: assert property (@(posedge clk) disable iff (rst)
        (gnt_vld_o[P_MAIN] && ent_cls[gnt_idx_o[P_MAIN]] == UC_SIMP)
            |-> (gnt_vld_o[P_SIMP] || busy_i[P_SIMP]))
        else $error("simple op skipped port 1"); // R6
    AST_RESET_EMPTY: assert property (@(posedge clk)
        rst |=> (ent_vld_o == '0))
        else $error("entries survive reset"); // R10

endmodule

// File: tb/uop_dispatch_sel_bench.sv
module uop_dispatch_sel_bench;

    localparam int N  = 8;
    localparam int IW = 3;

    logic                clk = 1'b0;
    logic                rst;
    logic                alloc_vld_i;
    logic [IW-1:0]       alloc_idx_i;
    logic [2:0]          alloc_cls_i;
    logic [N-1:0]        rdy_i;
    logic [4:0]          busy_i;
    logic [4:0]          gnt_vld_o;
    logic [4:0][IW-1:0]  gnt_idx_o;
    logic [N-1:0]        ent_vld_o;

    uop_dispatch_sel #(.ENTRIES(N)) u_uop_dispatch_sel (
        .clk(clk), .rst(rst),
        .alloc_vld_i(alloc_vld_i), .alloc_idx_i(alloc_idx_i), .alloc_cls_i(alloc_cls_i),
        .rdy_i(rdy_i), .busy_i(busy_i),
        .gnt_vld_o(gnt_vld_o), .gnt_idx_o(gnt_idx_o), .ent_vld_o(ent_vld_o)
    );

    always #10 clk = ~clk;   // 50 MHz

    localparam logic [2:0] C_CPLX = 3'd0, C_SIMP = 3'd1, C_FP = 3'd2,
                           C_LOAD = 3'd3, C_STA  = 3'd4, C_STD = 3'd5;

    typedef struct {
        logic [4:0]          vld;
        logic [4:0][IW-1:0]  idx;
        logic [N-1:0]        occ;
        string               tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // Monitor: sample a quarter period after the driving edge
    initial begin
        forever begin
            @(negedge clk);
            #5;
            while (exp_q.size() > 0) begin
                exp_t e;
                logic ok;
                e  = exp_q.pop_front();
                ok = (gnt_vld_o === e.vld) && (ent_vld_o === e.occ);
                for (int p = 0; p < 5; p++)
                    if (e.vld[p] && gnt_idx_o[p] !== e.idx[p]) ok = 1'b0;
                n_chk++;
                if (!ok) begin
                    n_fail++;
                    $display("FAIL %s: actual vld=%b idx=%h occ=%h expected vld=%b idx=%h occ=%h",
                             e.tag, gnt_vld_o, gnt_idx_o, ent_vld_o, e.vld, e.idx, e.occ);
                end
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; alloc_vld_i = 1'b0; rdy_i = '0; busy_i = '0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic alloc(input int idx, input logic [2:0] cls);
        @(negedge clk);
        alloc_vld_i = 1'b1; alloc_idx_i = IW'(idx); alloc_cls_i = cls;
        rdy_i = '0; busy_i = '0;
    endtask

    // Driver: apply one cycle of stimulus and queue what must appear
    task automatic step(input logic [N-1:0] rdy, input logic [4:0] busy,
                        input logic [4:0] vld, input int i0, input int i1,
                        input int i2, input int i3, input int i4,
                        input logic [N-1:0] occ, input string tag);
        exp_t e;
        @(negedge clk);
        alloc_vld_i = 1'b0; rdy_i = rdy; busy_i = busy;
        e.vld = vld;
        e.idx = {IW'(i4), IW'(i3), IW'(i2), IW'(i1), IW'(i0)};
        e.occ = occ;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    initial begin
        rst = 1'b1; alloc_vld_i = 1'b0; alloc_idx_i = '0; alloc_cls_i = '0;
        rdy_i = '0; busy_i = '0;
        do_reset();

        // R10: empty after reset; R1: nothing granted with all ready bits set
        step('1, 5'b0, 5'b00000, 0,0,0,0,0, 8'h00, "R10 reset empty / R1 no entries");

        // Mixed pool, written out of index order
        alloc(3, C_SIMP); alloc(5, C_SIMP); alloc(1, C_CPLX); alloc(0, C_LOAD);
        alloc(2, C_STA);  alloc(4, C_STD);  alloc(6, C_FP);
        step(8'h00, 5'b0, 5'b00000, 0,0,0,0,0, 8'h7F, "R1 not ready held");
        // R5 R6 R4 R7: older simple e5 beats complex e1 on port 0
        step(8'hFF, 5'b0, 5'b11111, 5,3,0,2,4, 8'h7F, "R6 simple fallback older than complex");
        // R8 freed; R2 complex before float by age
        step(8'hFF, 5'b0, 5'b00001, 1,0,0,0,0, 8'h42, "R8 R2 complex on port 0");
        step(8'hFF, 5'b0, 5'b00001, 6,0,0,0,0, 8'h40, "R2 float on port 0");
        step(8'hFF, 5'b0, 5'b00000, 0,0,0,0,0, 8'h00, "R8 pool drained");

        // R6: simple goes to port 1 while older complex takes port 0
        alloc(0, C_CPLX); alloc(1, C_SIMP); alloc(2, C_SIMP);
        step(8'hFF, 5'b0, 5'b00011, 0,1,0,0,0, 8'h07, "R6 simple prefers port 1");
        step(8'hFF, 5'b0, 5'b00010, 0,2,0,0,0, 8'h04, "R3 second simple on port 1");
        step(8'hFF, 5'b0, 5'b00000, 0,0,0,0,0, 8'h00, "R8 drained");

        // R9: busy port 1 pushes simple onto port 0; busy port 0 silences it
        alloc(0, C_SIMP); alloc(1, C_FP); alloc(2, C_SIMP);
        step(8'hFF, 5'b00010, 5'b00001, 0,0,0,0,0, 8'h07, "R9 port 1 busy fallback");
        step(8'hFF, 5'b00011, 5'b00000, 0,0,0,0,0, 8'h06, "R9 ports 0 and 1 busy");
        step(8'hFF, 5'b00000, 5'b00011, 1,2,0,0,0, 8'h06, "R9 busy released");
        step(8'hFF, 5'b0, 5'b00000, 0,0,0,0,0, 8'h00, "R8 drained");

        // R5 age independent of index; R8 write to occupied entry ignored
        alloc(7, C_LOAD); alloc(2, C_LOAD); alloc(5, C_LOAD);
        alloc(2, C_STD);
        step(8'h00, 5'b0, 5'b00000, 0,0,0,0,0, 8'hA4, "R8 occupied write ignored");
        step(8'hA0, 5'b0, 5'b00100, 0,0,7,0,0, 8'hA4, "R5 oldest load e7");
        step(8'hFF, 5'b0, 5'b00100, 0,0,2,0,0, 8'h24, "R5 R8 e2 kept load class");
        step(8'hFF, 5'b0, 5'b00100, 0,0,5,0,0, 8'h20, "R5 youngest load last");
        step(8'hFF, 5'b0, 5'b00000, 0,0,0,0,0, 8'h00, "R8 drained");

        // R4 R9: memory ports masked, then dedicated grants
        alloc(0, C_STA); alloc(1, C_STD);
        step(8'hFF, 5'b11100, 5'b00000, 0,0,0,0,0, 8'h03, "R9 memory ports busy");
        step(8'hFF, 5'b00000, 5'b11000, 0,0,0,0,1, 8'h03, "R4 store ports dedicated");
        step(8'hFF, 5'b0, 5'b00000, 0,0,0,0,0, 8'h00, "R8 drained");

        // R10: reset in the middle of a run
        alloc(3, C_CPLX); alloc(4, C_SIMP);
        do_reset();
        step(8'hFF, 5'b0, 5'b00000, 0,0,0,0,0, 8'h00, "R10 reset clears pool");

        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule